// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Programmable Framing

This block turns bytes queued in a small internal FIFO into asynchronous serial frames on a single output line. Bit timing comes from an external enable pulse at sixteen times the bit rate, so one bit period is sixteen of those pulses. The character width can be set from five to eight bits, and the parity mode and stop length can also be set. The stop length can be one, one and a half or two bit periods. A frame is a low start bit, then the data bits least significant first, then an optional parity bit, then the high stop period. Depending on these settings a frame lasts 7 to 12 bit periods.

A host pushes bytes with a write strobe and sets the global enable to let the transmitter run. While data is waiting and the enable is high, frames follow one another with no idle gap. A break input pulls the line low for as long as it is held. The outputs report when the FIFO is full, when a frame is in progress, and when the transmitter has fully drained. The format settings are captured at the moment each character is loaded.

Top module: `uart_tx_fmt`

## Requirements
- R1: After reset, txd is 1, busy is 0, tx_empty is 1 and fifo_full is 0.
- R2: A frame starts with txd low for one bit, then the data bits least significant first. The number of data bits is cfg_len+5 (code 0 gives 5 bits, code 3 gives 8). Every bit lasts exactly 16 tick pulses, and txd changes only on a tick while busy.
- R3: cfg_par 1 selects even parity: the parity bit is the XOR of the transmitted data bits. Code 2 selects odd parity: the parity bit is the inverse of that XOR. Codes 0 and 3 send no parity bit. The parity bit follows the last data bit and lasts 16 ticks.
- R4: The stop period is high for 16 ticks with cfg_stop 0, 24 ticks with code 1, and 32 ticks with codes 2 and 3.
- R5: A whole frame lasts 16*(1+bits+parity)+stop ticks, which spans 7 to 12 bit periods.
- R6: While en is low and no frame is in progress, nothing is sent: txd stays high and busy stays low, even with data queued.
- R7: If data is queued and en is high when a stop period ends, the next start bit begins on the very next tick.
- R8: If en is cleared in the middle of a frame, that frame still completes in full. The transmitter then idles and keeps the remaining data queued.
- R9: tx_empty is 1 only when the FIFO is empty and no frame (stop period included) is in progress. busy is 1 from the load of a character until its stop period ends.
- R10: While brk is 1, txd is 0.
- R11: The FIFO holds FIFO_DEPTH characters (default 4) and raises fifo_full when it holds that many. A write while the FIFO is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Global transmit enable |
| brk | input | 1 | Forces the line low while high |
| tick | input | 1 | One-cycle pulse at 16x the bit rate |
| cfg_len | input | 2 | Data bits minus five |
| cfg_par | input | 2 | 0 none, 1 even, 2 odd, 3 none |
| cfg_stop | input | 2 | 0 one, 1 one and a half, 2/3 two stop bits |
| wr_valid | input | 1 | Push wr_data into the FIFO |
| wr_data | input | 8 | Character to send |
| fifo_full | output | 1 | FIFO holds FIFO_DEPTH characters |
| txd | output | 1 | Serial line, idles high |
| busy | output | 1 | Frame in progress |
| tx_empty | output | 1 | FIFO empty and frame finished |

## Verification
Several properties are checked on every clock cycle. They cover the break override, the high idle line, busy rising only after an enabled load, tx_empty never overlapping busy, the FIFO occupancy bound, and the rule that the line moves only on a tick. The exact bit order, the parity values, the stop lengths, the seamless chaining of frames and the frame that finishes after the enable is cleared are all sequences over hundreds of ticks. Only the bench's scenarios can show them. The bench compares the line, tick by tick, against waveforms it builds from each setting.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int CHAR_W        = 8;
    localparam int TICKS_PER_BIT = 16;
    localparam int TCNT_W        = 5;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ODD  = 2'd2,
        PAR_OFF  = 2'd3
    } par_mode_e;

    typedef enum logic [1:0] {
        STOP_ONE      = 2'd0,
        STOP_ONE_HALF = 2'd1,
        STOP_TWO      = 2'd2,
        STOP_TWO_ALT  = 2'd3
    } stop_mode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP
    } tx_state_e;

    typedef struct packed {
        logic [1:0] len_code;
        par_mode_e  par;
        stop_mode_e stop;
    } frame_cfg_t;

    function automatic logic [3:0] data_bits(input logic [1:0] code);
        return 4'd5 + {2'b00, code};
    endfunction

    function automatic logic has_parity(input par_mode_e p);
        return (p == PAR_EVEN) || (p == PAR_ODD);
    endfunction

    // last tick index of the stop period: 16, 24 or 32 ticks
    function automatic logic [TCNT_W-1:0] stop_last_tick(input stop_mode_e s);
        case (s)
            STOP_ONE:      return TCNT_W'(TICKS_PER_BIT - 1);
            STOP_ONE_HALF: return TCNT_W'(TICKS_PER_BIT + TICKS_PER_BIT/2 - 1);
            default:       return TCNT_W'(2*TICKS_PER_BIT - 1);
        endcase
    endfunction

    function automatic logic parity_of(input logic [CHAR_W-1:0] d,
                                       input logic [1:0] code,
                                       input par_mode_e p);
        logic [CHAR_W-1:0] mask;
        logic x;
        mask = CHAR_W'((9'd1 << data_bits(code)) - 9'd1);
        x = ^(d & mask);
        return (p == PAR_ODD) ? ~x : x;
    endfunction

endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [W-1:0]                 wr_data,
    input  logic                         rd_en,
    output logic [W-1:0]                 rd_data,
    output logic                         empty,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          push, pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign push    = wr_en && !full;
    assign pop     = rd_en && !empty;
    assign rd_data = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= wr_data;
                wr_ptr      <= bump(wr_ptr);
            end
            if (pop) rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer
    import uart_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              tick,
    input  frame_cfg_t        cfg,
    input  logic              q_empty,
    input  logic [CHAR_W-1:0] q_data,
    output logic              q_pop,
    output logic              line,
    output logic              busy
);
    localparam logic [TCNT_W-1:0] BIT_LAST = TCNT_W'(TICKS_PER_BIT - 1);

    tx_state_e         state;
    logic [TCNT_W-1:0] tcnt;
    logic [2:0]        bit_idx;
    logic [CHAR_W-1:0] shreg;
    frame_cfg_t        cfg_q;
    logic              par_q;
    logic              stop_done, bit_done, load;

    assign bit_done  = tick && (tcnt == BIT_LAST);
    assign stop_done = (state == S_STOP) && tick && (tcnt == stop_last_tick(cfg_q.stop));
    assign load      = en && !q_empty && ((state == S_IDLE) || stop_done);
    assign q_pop     = load;
    assign busy      = (state != S_IDLE);

    always_comb begin
        case (state)
            S_START: line = 1'b0;
            S_DATA:  line = shreg[0];
            S_PAR:   line = par_q;
            default: line = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            tcnt    <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            cfg_q   <= '0;
            par_q   <= 1'b0;
        end else if (load) begin
            state   <= S_START;
            tcnt    <= '0;
            bit_idx <= '0;
            shreg   <= q_data;
            cfg_q   <= cfg;
            par_q   <= parity_of(q_data, cfg.len_code, cfg.par);
        end else if (tick) begin
            case (state)
                S_START: begin
                    tcnt <= bit_done ? '0 : tcnt + TCNT_W'(1);
                    if (bit_done) state <= S_DATA;
                end
                S_DATA: begin
                    tcnt <= bit_done ? '0 : tcnt + TCNT_W'(1);
                    if (bit_done) begin
                        shreg <= shreg >> 1;
                        if ({1'b0, bit_idx} == data_bits(cfg_q.len_code) - 4'd1)
                            state <= has_parity(cfg_q.par) ? S_PAR : S_STOP;
                        else
                            bit_idx <= bit_idx + 3'd1;
                    end
                end
                S_PAR: begin
                    tcnt <= bit_done ? '0 : tcnt + TCNT_W'(1);
                    if (bit_done) state <= S_STOP;
                end
                S_STOP: begin
                    if (stop_done) begin
                        state <= S_IDLE;
                        tcnt  <= '0;
                    end else begin
                        tcnt <= tcnt + TCNT_W'(1);
                    end
                end
                default: tcnt <= '0;
            endcase
        end
    end
endmodule

// File: rtl/uart_tx_fmt.sv
module uart_tx_fmt
    import uart_tx_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       brk,
    input  logic       tick,
    input  logic [1:0] cfg_len,
    input  logic [1:0] cfg_par,
    input  logic [1:0] cfg_stop,
    input  logic       wr_valid,
    input  logic [7:0] wr_data,
    output logic       fifo_full,
    output logic       txd,
    output logic       busy,
    output logic       tx_empty
);
    localparam int CW = $clog2(FIFO_DEPTH+1);

    frame_cfg_t        cfg;
    logic [CHAR_W-1:0] q_data;
    logic              q_empty, q_pop, line;
    logic [CW-1:0]     fifo_count;

    assign cfg.len_code = cfg_len;
    assign cfg.par      = par_mode_e'(cfg_par);
    assign cfg.stop     = stop_mode_e'(cfg_stop);

    uart_tx_fifo #(.W(CHAR_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_valid),
        .wr_data (wr_data),
        .rd_en   (q_pop),
        .rd_data (q_data),
        .empty   (q_empty),
        .full    (fifo_full),
        .count   (fifo_count)
    );

    uart_tx_serializer u_ser (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .tick    (tick),
        .cfg     (cfg),
        .q_empty (q_empty),
        .q_data  (q_data),
        .q_pop   (q_pop),
        .line    (line),
        .busy    (busy)
    );

    assign txd      = brk ? 1'b0 : line;
    assign tx_empty = q_empty && !busy;
endmodule

// File: rtl/uart_tx_fmt_chk.sv
module uart_tx_fmt_chk #(
    parameter int DEPTH = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       en,
    input logic                       brk,
    input logic                       tick,
    input logic                       txd,
    input logic                       busy,
    input logic                       tx_empty,
    input logic [$clog2(DEPTH+1)-1:0] fifo_count
);
    // R10
    brk_low_chk: assert property (@(posedge clk) disable iff (rst)
        brk |-> !txd);

    // R2
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !brk) |-> txd);

    // R9
    empty_idle_chk: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> !busy);

    // R6
    start_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(en));

    // R11
    fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_count <= ($clog2(DEPTH+1))'(DEPTH));

    // R2
    tick_paced_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(busy) && !$past(tick) && !brk && !$past(brk)) |-> $stable(txd));
endmodule

bind uart_tx_fmt uart_tx_fmt_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .brk        (brk),
    .tick       (tick),
    .txd        (txd),
    .busy       (busy),
    .tx_empty   (tx_empty),
    .fifo_count (fifo_count)
);

// File: tb/uart_tx_fmt_tb.sv
module uart_tx_fmt_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0, brk = 1'b0, tick = 1'b0, wr_valid = 1'b0;
    logic [1:0] cfg_len = 2'd3, cfg_par = 2'd0, cfg_stop = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic       fifo_full, txd, busy, tx_empty;

    int errors = 0;
    int checks = 0;
    int tdiv   = 0;
    bit exp_q[$];

    always #5 clk = ~clk;

    uart_tx_fmt u_dut (
        .clk(clk), .rst(rst), .en(en), .brk(brk), .tick(tick),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop(cfg_stop),
        .wr_valid(wr_valid), .wr_data(wr_data),
        .fifo_full(fifo_full), .txd(txd), .busy(busy), .tx_empty(tx_empty)
    );

    // one tick every third clock
    always @(negedge clk) begin
        tdiv <= (tdiv == 2) ? 0 : tdiv + 1;
        tick <= (tdiv == 2);
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // value of txd held until the next tick is consumed
    task automatic next_tick(output logic v);
        do begin
            @(negedge clk);
            #1;
        end while (!tick);
        v = txd;
    endtask

    task automatic push(input logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic add_bits(input bit v, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(v);
    endtask

    task automatic build_frame(input int len, input int par, input int stp,
                               input logic [7:0] d);
        int nb;
        bit x;
        nb = len + 5;
        x  = 1'b0;
        add_bits(1'b0, 16);
        for (int b = 0; b < nb; b++) begin
            add_bits(d[b], 16);
            x ^= d[b];
        end
        if (par == 1) add_bits(x, 16);
        if (par == 2) add_bits(!x, 16);
        add_bits(1'b1, (stp == 0) ? 16 : (stp == 1) ? 24 : 32);
    endtask

    // waits for the start bit, then compares the whole expected queue
    task automatic run_compare(input string req, input string what);
        logic v;
        int   n, bad, first_i, first_a, first_e, waited;
        n = exp_q.size();
        waited = 0;
        do begin
            next_tick(v);
            waited++;
        end while (v !== 1'b0 && waited < 3000);
        bad = 0; first_i = -1; first_a = 0; first_e = 0;
        for (int i = 0; i < n; i++) begin
            if (i > 0) next_tick(v);
            if (v !== exp_q[i]) begin
                if (bad == 0) begin
                    first_i = i; first_a = int'(v); first_e = int'(exp_q[i]);
                end
                bad++;
            end
        end
        check(bad == 0 && waited < 3000, req, what, first_i, -1);
        if (bad != 0)
            $display("  first mismatch at tick %0d: line=%0d want=%0d", first_i, first_a, first_e);
        exp_q.delete();
    endtask

    initial begin
        logic v;
        bit   all_high;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        // R1
        check(txd === 1'b1, "R1", "txd after reset", int'(txd), 1);
        check(busy === 1'b0, "R1", "busy after reset", int'(busy), 0);
        check(tx_empty === 1'b1, "R1", "tx_empty after reset", int'(tx_empty), 1);
        check(fifo_full === 1'b0, "R1", "fifo_full after reset", int'(fifo_full), 0);

        // R10: break while idle
        @(negedge clk); brk = 1'b1;
        @(negedge clk); #1;
        check(txd === 1'b0, "R10", "txd during break", int'(txd), 0);
        brk = 1'b0;
        @(negedge clk); #1;
        check(txd === 1'b1, "R10", "txd after break", int'(txd), 1);

        // R2 R3 R4 R5: sweep every format setting, one frame each
        for (int len = 0; len < 4; len++)
            for (int par = 0; par < 4; par++)
                for (int stp = 0; stp < 4; stp++) begin
                    logic [7:0] d;
                    d = 8'hA5 ^ 8'((len * 16 + par * 4 + stp) * 37);
                    cfg_len  = 2'(len);
                    cfg_par  = 2'(par);
                    cfg_stop = 2'(stp);
                    build_frame(len, (par == 3) ? 0 : par, (stp == 3) ? 2 : stp, d);
                    push(d);
                    en = 1'b1;
                    run_compare("R2/R3/R4/R5", $sformatf("frame len=%0d par=%0d stop=%0d",
                                len, par, stp));
                    next_tick(v);
                    // R9
                    check(tx_empty === 1'b1 && busy === 1'b0, "R9",
                          "drained after stop", int'(tx_empty), 1);
                    en = 1'b0;
                end

        // R6 R11: disabled transmitter with a full FIFO
        cfg_len = 2'd3; cfg_par = 2'd0; cfg_stop = 2'd0;
        for (int i = 0; i < 5; i++) push(8'h30 + 8'(i));
        #1;
        check(fifo_full === 1'b1, "R11", "fifo_full after overfill", int'(fifo_full), 1);
        all_high = 1'b1;
        for (int i = 0; i < 40; i++) begin
            next_tick(v);
            if (v !== 1'b1 || busy !== 1'b0) all_high = 1'b0;
        end
        check(all_high, "R6", "line idle while disabled", int'(all_high), 1);
        check(tx_empty === 1'b0, "R9", "tx_empty with queued data", int'(tx_empty), 0);

        // R7 R11: four frames back to back, the fifth write was dropped
        for (int i = 0; i < 4; i++) build_frame(3, 0, 0, 8'h30 + 8'(i));
        en = 1'b1;
        run_compare("R7/R11", "four chained frames");
        all_high = 1'b1;
        for (int i = 0; i < 40; i++) begin
            next_tick(v);
            if (v !== 1'b1) all_high = 1'b0;
        end
        check(all_high && tx_empty === 1'b1, "R11", "no fifth frame", int'(all_high), 1);

        // R8: clear enable in the middle of a frame
        cfg_len = 2'd1; cfg_par = 2'd1; cfg_stop = 2'd1;
        en = 1'b0;
        push(8'h2D);
        push(8'h13);
        build_frame(1, 1, 1, 8'h2D);
        en = 1'b1;
        fork
            run_compare("R8", "frame finishing after enable drop");
            begin
                repeat (60) next_tick(v);
                check(busy === 1'b1 && tx_empty === 1'b0, "R9", "busy mid frame", int'(busy), 1);
                en = 1'b0;
            end
        join
        all_high = 1'b1;
        for (int i = 0; i < 60; i++) begin
            next_tick(v);
            if (v !== 1'b1 || busy !== 1'b0) all_high = 1'b0;
        end
        check(all_high, "R8", "idle after enable drop", int'(all_high), 1);
        check(tx_empty === 1'b0, "R8", "remaining data kept", int'(tx_empty), 0);
        build_frame(1, 1, 1, 8'h13);
        en = 1'b1;
        run_compare("R8", "held frame sent on re-enable");
        next_tick(v);
        check(tx_empty === 1'b1, "R9", "drained at end", int'(tx_empty), 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(10 * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule